// File: doc/BRIEF.md
# Pin-Driven Non-Volatile Transfer Mode Controller

This block sits between four active-low host control pins and the data path of a memory that keeps a volatile array shadowed by a non-volatile copy. On each clock it samples chip enable, write enable, output enable and non-volatile enable. From them it works out one operating mode: standby, array read, array write, store (volatile to non-volatile), recall (non-volatile to volatile) or no-op. It then grants read and write strobes to the array and decides whether the data bus drivers are on.

Store and recall are handed to a separate transfer engine as single-cycle command pulses. The engine signals the end of a transfer with a completion pulse. A transfer is only accepted after a high-to-low transition of the non-volatile enable pin. A host that keeps the pins in a transfer state therefore gets one transfer, not a stream of them. A part that comes out of reset with that pin already low starts nothing. While a transfer runs, every pin is ignored. Once it finishes, whatever read or write state is on the pins is acted on in the next cycle.

Top module: `nvmode_ctrl`

## Requirements
- R1: With chip enable high the mode is standby (mode code 0). No read strobe, write strobe, bus drive or transfer command is given, whatever the other pins are.
- R2: With chip enable low, write enable high, output enable low and non-volatile enable high, the mode is read (code 1). The read strobe and bus drive are both high.
- R3: With chip enable low, write enable low and non-volatile enable high, the mode is write (code 2) and the write strobe is high. The bus drive is low at either output-enable level.
- R4: With chip enable low, write enable low, output enable high and non-volatile enable low, the mode is store (code 3). When armed, this state gives a one-cycle store command and the block is busy from the next cycle.
- R5: With chip enable low, write enable high, output enable low and non-volatile enable low, the mode is recall (code 4). When armed, this state gives a one-cycle recall command and the block is busy from the next cycle.
- R6: Two pin states are no-op (code 5): all four pins low, and chip enable low with write enable and output enable both high. A no-op gives no strobe, no bus drive and no command.
- R7: The arm flag is cleared when a command is given and set only by a later falling edge of non-volatile enable. If the pins stay in the store or recall state after completion, no second command is given.
- R8: The arm flag is clear out of reset. If non-volatile enable is already low when reset is released, the store state gives no command.
- R9: While busy, the mode reads as transfer (code 6) and all strobes, the bus drive and the commands are low. Pin changes are ignored, and that includes a falling edge of non-volatile enable.
- R10: The completion input ends the busy state. A read or write state present on the pins takes effect in the first cycle after completion.
- R11: A transfer starts in the cycle where the last of the four pins reaches the transfer state. The arming edge may come earlier, including while chip enable is high.
- R12: Store and recall commands are never high together, and each stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| ne_n | input | 1 | Non-volatile enable pin, active low |
| xfer_done | input | 1 | Completion pulse from the transfer engine |
| store_go | output | 1 | One-cycle store command |
| recall_go | output | 1 | One-cycle recall command |
| busy | output | 1 | Transfer in progress; pins are ignored |
| sram_rd_en | output | 1 | Array read strobe |
| sram_wr_en | output | 1 | Array write strobe |
| dq_oe | output | 1 | Data bus driver enable |
| mode_o | output | 3 | Current mode code (0 standby, 1 read, 2 write, 3 store, 4 recall, 5 no-op, 6 transfer) |

## Verification
The bench goes after the retrigger hazards:
- It holds the store state through completion. A design that re-armed on level rather than edge would start a second store.
- It releases reset with non-volatile enable low. A design that seeded its edge detector high would fire a store at power-up.
- It drops non-volatile enable during a busy transfer. A design that kept watching edges while busy would be wrongly armed when the transfer ends.
- It arms with chip enable high and only then lowers chip enable. A design that required the edge and the full state in the same cycle would never start that recall.
- It checks that a write issued with output enable low keeps the bus off.
- It checks that read and write states take effect in the first cycle after completion, not one cycle late.

// File: rtl/nvmode_pkg.sv
// Shared types for the non-volatile mode controller.
// Assumes: all pins active low, sampled synchronously to clk.
package nvmode_pkg;

    // One sample of the four host control pins
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic ne_n;
    } pins_t;

    localparam int MODE_W = 3;

    // Operating mode; the codes are visible on mode_o
    typedef enum logic [MODE_W-1:0] {
        MODE_STANDBY = 3'd0,
        MODE_READ    = 3'd1,
        MODE_WRITE   = 3'd2,
        MODE_STORE   = 3'd3,
        MODE_RECALL  = 3'd4,
        MODE_NOP     = 3'd5,
        MODE_XFER    = 3'd6
    } mode_t;

    // Reset image of the pin sampler: deselected, and non-volatile enable
    // seen low so that a pin held low through reset yields no falling edge.
    localparam pins_t PINS_RST = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, ne_n: 1'b0};

endpackage

// File: rtl/nvmode_capture.sv
// Pin sampler: registers the control pins through IN_STAGES flops and
// flags a high-to-low transition of non-volatile enable at the last stage.
// Assumes: the pins are already synchronous to clk (no metastability handling
// beyond the stage count chosen by the integrator).
module nvmode_capture
    import nvmode_pkg::*;
#(
    parameter int IN_STAGES = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins_i,
    output pins_t pins_o,
    output logic  ne_fall_o
);
    localparam int LAST = IN_STAGES - 1;

    pins_t stage [IN_STAGES];
    logic  ne_prev;

    // Shift the pin sample through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < IN_STAGES; i++) stage[i] <= PINS_RST;
        end else begin
            stage[0] <= pins_i;
            for (int i = 1; i < IN_STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    // Remember last cycle's non-volatile enable for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ne_prev <= 1'b0;
        else        ne_prev <= stage[LAST].ne_n;
    end

    assign pins_o    = stage[LAST];
    assign ne_fall_o = ne_prev & ~stage[LAST].ne_n;

endmodule

// File: rtl/nvmode_decode.sv
// Mode decoder: maps one pin sample onto an operating mode.
// Assumes: input already registered; purely combinational.
module nvmode_decode
    import nvmode_pkg::*;
(
    input  pins_t pins_i,
    output mode_t mode_o
);
    // Priority: chip enable, then write with non-volatile disabled, then the
    // output-enable / non-volatile pairs
    always_comb begin
        if (pins_i.ce_n)
            mode_o = MODE_STANDBY;
        else if (!pins_i.we_n && pins_i.ne_n)
            mode_o = MODE_WRITE;
        else if (pins_i.we_n && !pins_i.oe_n)
            mode_o = pins_i.ne_n ? MODE_READ : MODE_RECALL;
        else if (!pins_i.we_n && pins_i.oe_n)
            mode_o = MODE_STORE;
        else
            mode_o = MODE_NOP;
    end

endmodule

// File: rtl/nvmode_seq.sv
// Transfer sequencer: holds the edge arm flag and the busy state, issues
// one-cycle store/recall commands and gates array access while busy.
// Assumes: xfer_done_i is a pulse from the engine; done outside busy is ignored.
module nvmode_seq
    import nvmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode_i,
    input  logic  ne_fall_i,
    input  logic  xfer_done_i,
    output logic  store_go_o,
    output logic  recall_go_o,
    output logic  busy_o,
    output logic  rd_en_o,
    output logic  wr_en_o,
    output logic  dq_oe_o,
    output mode_t mode_o
);
    logic armed_q;
    logic busy_q;
    logic can_issue;
    logic any_go;

    // A command needs an idle block and an edge seen now or earlier
    assign can_issue   = !busy_q && (armed_q || ne_fall_i);
    assign store_go_o  = can_issue && (mode_i == MODE_STORE);
    assign recall_go_o = can_issue && (mode_i == MODE_RECALL);
    assign any_go      = store_go_o || recall_go_o;

    // Arm on a falling edge while idle; disarm when a command leaves
    always_ff @(posedge clk) begin
        if (!rst_n)                    armed_q <= 1'b0;
        else if (any_go)               armed_q <= 1'b0;
        else if (ne_fall_i && !busy_q) armed_q <= 1'b1;
    end

    // Busy from the cycle after a command until the engine reports done
    always_ff @(posedge clk) begin
        if (!rst_n)           busy_q <= 1'b0;
        else if (any_go)      busy_q <= 1'b1;
        else if (xfer_done_i) busy_q <= 1'b0;
    end

    assign busy_o  = busy_q;
    assign rd_en_o = !busy_q && (mode_i == MODE_READ);
    assign wr_en_o = !busy_q && (mode_i == MODE_WRITE);
    assign dq_oe_o = rd_en_o;
    assign mode_o  = busy_q ? MODE_XFER : mode_i;

    // R12
    go_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_go_o, recall_go_o}));

    // R12
    go_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_go_o || recall_go_o) |=> !(store_go_o || recall_go_o));

    // R4
    go_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_go_o || recall_go_o) |=> busy_o);

    // R7
    go_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_go_o || recall_go_o) |=> !armed_q);

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(rd_en_o || wr_en_o || dq_oe_o || store_go_o || recall_go_o));

    // R9
    busy_holds_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !armed_q) |=> !armed_q);

    // R6
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_NOP) |-> !(rd_en_o || wr_en_o || dq_oe_o || store_go_o || recall_go_o));

endmodule

// File: rtl/nvmode_ctrl.sv
// Top of the pin-driven non-volatile mode controller: samples the host pins,
// decodes the mode and sequences store/recall commands to a transfer engine.
// Assumes: pins synchronous to clk; engine answers each command with one
// xfer_done pulse.
module nvmode_ctrl
    import nvmode_pkg::*;
#(
    parameter int IN_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ne_n,
    input  logic              xfer_done,
    output logic              store_go,
    output logic              recall_go,
    output logic              busy,
    output logic              sram_rd_en,
    output logic              sram_wr_en,
    output logic              dq_oe,
    output logic [MODE_W-1:0] mode_o
);
    pins_t pins_raw;
    pins_t pins_q;
    logic  ne_fall;
    mode_t mode_dec;
    mode_t mode_out;

    assign pins_raw = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n, ne_n: ne_n};

    nvmode_capture #(.IN_STAGES(IN_STAGES)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_i    (pins_raw),
        .pins_o    (pins_q),
        .ne_fall_o (ne_fall)
    );

    nvmode_decode u_decode (
        .pins_i (pins_q),
        .mode_o (mode_dec)
    );

    nvmode_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_dec),
        .ne_fall_i   (ne_fall),
        .xfer_done_i (xfer_done),
        .store_go_o  (store_go),
        .recall_go_o (recall_go),
        .busy_o      (busy),
        .rd_en_o     (sram_rd_en),
        .wr_en_o     (sram_wr_en),
        .dq_oe_o     (dq_oe),
        .mode_o      (mode_out)
    );

    assign mode_o = mode_out;

    // R1
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_q.ce_n && !busy) |-> (mode_o == MODE_STANDBY) &&
        !(sram_rd_en || sram_wr_en || dq_oe || store_go || recall_go));

    // R3
    write_bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_wr_en |-> !dq_oe);

    // R2
    read_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_rd_en |-> dq_oe);

endmodule

// File: tb/nvmode_ctrl_tb.sv
module nvmode_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ne_n = 1'b1;
    logic       xfer_done = 1'b0;
    logic       store_go, recall_go, busy, sram_rd_en, sram_wr_en, dq_oe;
    logic [2:0] mode_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [2:0] STB = 3'd0, RD = 3'd1, WR = 3'd2, ST = 3'd3,
                           RC = 3'd4, NOP = 3'd5, XF = 3'd6;

    always #5 clk = ~clk;

    nvmode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .ne_n(ne_n), .xfer_done(xfer_done), .store_go(store_go),
        .recall_go(recall_go), .busy(busy), .sram_rd_en(sram_rd_en),
        .sram_wr_en(sram_wr_en), .dq_oe(dq_oe), .mode_o(mode_o)
    );

    // Expected vector: {mode, busy, store_go, recall_go, rd, wr, oe}
    function automatic logic [8:0] ev(logic [2:0] m, logic b, logic sg,
                                      logic rg, logic rd, logic wr, logic oe);
        return {m, b, sg, rg, rd, wr, oe};
    endfunction

    task automatic check(string req, logic [8:0] exp);
        logic [8:0] act;
        act = {mode_o, busy, store_go, recall_go, sram_rd_en, sram_wr_en, dq_oe};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Drive pins at a falling edge, wait one cycle, outputs then reflect them
    task automatic step(logic c, logic w, logic o, logic n);
        ce_n = c; we_n = w; oe_n = o; ne_n = n;
        @(negedge clk);
    endtask

    task automatic do_reset(logic c, logic w, logic o, logic n);
        rst_n = 1'b0; ce_n = c; we_n = w; oe_n = o; ne_n = n;
        repeat (3) @(negedge clk);
        check("R1 reset", ev(STB, 0, 0, 0, 0, 0, 0));
        rst_n = 1'b1;
    endtask

    task automatic t_decode;
        step(1, 0, 0, 1); check("R1 standby", ev(STB, 0, 0, 0, 0, 0, 0));
        step(0, 1, 0, 1); check("R2 read",    ev(RD, 0, 0, 0, 1, 0, 1));
        step(0, 0, 0, 1); check("R3 write oe low", ev(WR, 0, 0, 0, 0, 1, 0));
        step(0, 0, 1, 1); check("R3 write oe high", ev(WR, 0, 0, 0, 0, 1, 0));
        step(0, 1, 1, 1); check("R6 nop we/oe high", ev(NOP, 0, 0, 0, 0, 0, 0));
        step(1, 1, 1, 1); check("R1 standby idle", ev(STB, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic t_store_busy_ignore;
        step(0, 0, 1, 1); check("R3 pre-store write", ev(WR, 0, 0, 0, 0, 1, 0));
        step(0, 0, 1, 0); check("R4 store cmd", ev(ST, 0, 1, 0, 0, 0, 0));
        step(0, 0, 1, 0); check("R12 store one cycle", ev(XF, 1, 0, 0, 0, 0, 0));
        step(0, 1, 0, 1); check("R9 read ignored busy", ev(XF, 1, 0, 0, 0, 0, 0));
        step(0, 1, 0, 0); check("R9 fall ignored busy", ev(XF, 1, 0, 0, 0, 0, 0));
        xfer_done = 1'b1;
        step(0, 1, 0, 0); check("R9 no arm from busy fall", ev(RC, 0, 0, 0, 0, 0, 0));
        xfer_done = 1'b0;
        step(0, 1, 0, 0); check("R9 still unarmed", ev(RC, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic t_recall_then_write;
        step(0, 1, 0, 1); check("R2 read again", ev(RD, 0, 0, 0, 1, 0, 1));
        step(0, 1, 0, 0); check("R5 recall cmd", ev(RC, 0, 0, 1, 0, 0, 0));
        step(0, 1, 0, 0); check("R5 busy", ev(XF, 1, 0, 0, 0, 0, 0));
        step(0, 0, 0, 1); check("R9 write ignored busy", ev(XF, 1, 0, 0, 0, 0, 0));
        xfer_done = 1'b1;
        step(0, 0, 0, 1); check("R10 write at done", ev(WR, 0, 0, 0, 0, 1, 0));
        xfer_done = 1'b0;
    endtask

    task automatic t_hold_no_retrigger;
        step(0, 0, 1, 0); check("R4 store cmd 2", ev(ST, 0, 1, 0, 0, 0, 0));
        step(0, 0, 1, 0); check("R4 busy", ev(XF, 1, 0, 0, 0, 0, 0));
        xfer_done = 1'b1;
        step(0, 0, 1, 0); check("R7 held store no retrigger", ev(ST, 0, 0, 0, 0, 0, 0));
        xfer_done = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 1, 0); check("R7 held store quiet", ev(ST, 0, 0, 0, 0, 0, 0));
        end
        step(0, 0, 0, 0); check("R6 all low nop", ev(NOP, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic t_arm_early;
        step(1, 1, 0, 1); check("R1 standby ne high", ev(STB, 0, 0, 0, 0, 0, 0));
        step(1, 1, 0, 0); check("R11 arm while deselected", ev(STB, 0, 0, 0, 0, 0, 0));
        step(0, 1, 0, 0); check("R11 recall on ce last", ev(RC, 0, 0, 1, 0, 0, 0));
        step(0, 1, 0, 0); check("R11 busy", ev(XF, 1, 0, 0, 0, 0, 0));
        xfer_done = 1'b1;
        step(1, 1, 1, 1); check("R10 standby at done", ev(STB, 0, 0, 0, 0, 0, 0));
        xfer_done = 1'b0;
    endtask

    task automatic t_powerup_low;
        do_reset(0, 0, 1, 0);
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 1, 0); check("R8 no store after reset", ev(ST, 0, 0, 0, 0, 0, 0));
        end
        step(0, 0, 1, 1); check("R8 write", ev(WR, 0, 0, 0, 0, 1, 0));
        step(0, 0, 1, 0); check("R8 store after real edge", ev(ST, 0, 1, 0, 0, 0, 0));
    endtask

    initial begin
        @(negedge clk);
        do_reset(1, 1, 1, 1);
        t_decode();
        t_store_busy_ignore();
        t_recall_then_write();
        t_hold_no_retrigger();
        t_arm_early();
        t_powerup_low();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule